// File: doc/BRIEF.md
# Converter Command and Readback Register Interface

This block is a memory-mapped register front end for the internal register file of an on-chip converter. Software issues 32-bit command words through a write-only command port. Each command reads, writes or does nothing to one 16-bit internal register. An array of 16-bit registers inside the block stands in for the converter's register file. Readback goes through a data FIFO with one command of latency. Each accepted command pushes the value latched by the command before it, then latches its own result. A read result therefore reaches the FIFO only when the following command is issued, which is usually a no-op.

Around the command path sit a configuration register, a sticky interrupt status register with write-one-to-clear bits, an interrupt mask, a read-only master status word and a master control register. A set hold bit in the master control register blocks all commands. One level interrupt output combines status and mask. The bus is a simple 32-bit word bus with single-cycle read and write strobes. All state changes on the clock edge that ends a strobe, and read data is returned on that same edge.

Top module: `adc_cmd_regif`

## Requirements
- R1: After synchronous reset the registers read as follows. Configuration reads 0x0000_1814: 0x14 in bits 4:0, the value 8 in the clock-rate field at bits 9:8 and up, and bit 12 set. Interrupt status reads 0x200, the mask reads 0xFFFF_FFFF and master control reads 0x10. The interrupt output is low and the data FIFO is empty.
- R2: The word registers sit at these byte addresses: 0x00 configuration, 0x04 interrupt status, 0x08 interrupt mask, 0x0C master status (read-only), 0x10 command port (write-only), 0x14 FIFO pop (read-only) and 0x18 master control. Unmapped, misaligned or wrong-direction reads return zero. Unmapped, misaligned or wrong-direction writes change nothing.
- R3: A command word holds the opcode in bits 29:26 (0 no-op, 1 read, 2 write), the register index in bits 25:16 and write data in bits 15:0. An accepted command first pushes the previously latched value into the FIFO. A read then latches the indexed register. A write stores the data in the register and latches zero. A no-op latches zero.
- R4: The data FIFO holds 15 entries. A push into a full FIFO is dropped, but the latch is still updated.
- R5: A read at 0x14 pops the oldest entry. A pop from an empty FIFO returns zero and the level stays zero.
- R6: While master control bit 4 is set, every command is ignored. Neither the FIFO, the latch nor the register file changes.
- R7: A read or write command whose index is 128 or higher is ignored. Opcodes 3 to 15 are ignored. A no-op is accepted whatever its index.
- R8: Writing the interrupt status register clears each bit written as one. Every bus strobe sets status bit 9.
- R9: Every bus strobe sets status bit 8 when the FIFO level after that edge exceeds configuration bits 19:16.
- R10: Mask writes keep only bits 9:0. The interrupt output is high when some status bit is set and its mask bit is clear.
- R11: Master status reads 1 in bit 10 and the FIFO level in bits 15:12. Bit 8 is set when the FIFO is empty and bit 9 when it is full. All other bits are zero.
- R12: Master control stores the written value ANDed with 0x00FF_FEFF. Configuration stores all 32 bits.
- R13: Read data appears on the read data port on the clock edge that ends the read strobe. The value returned is the register contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 8 | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Level interrupt |

## Verification
The embedded properties take the read and write strobes as mutually exclusive. They also take each strobe to last exactly one cycle per access. The FIFO-count and hold properties depend on this, because they assume a command write is never paired with a pop on the same edge. The stimulus drives every access from one task per direction. Each task raises a single strobe for one clock and then drops it, so the two strobes never overlap.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;

    localparam int BUS_W    = 32;
    localparam int SHADOW_W = 16;
    localparam int LEVEL_W  = 4;

    localparam logic [BUS_W-1:0] CFG_RESET_VAL  = 32'h0000_1814;
    localparam logic [BUS_W-1:0] STS_RESET_VAL  = 32'h0000_0200;
    localparam logic [BUS_W-1:0] MASK_RESET_VAL = 32'hFFFF_FFFF;
    localparam logic [BUS_W-1:0] MCTL_RESET_VAL = 32'h0000_0010;
    localparam logic [BUS_W-1:0] MCTL_KEEP      = 32'h00FF_FEFF;
    localparam logic [BUS_W-1:0] MASK_KEEP      = 32'h0000_03FF;

    localparam int STS_CMD_LOW   = 9;
    localparam int STS_DATA_HIGH = 8;
    localparam int MCTL_HOLD     = 4;
    localparam int THR_LSB       = 16;

    localparam logic [3:0] OP_NOP   = 4'd0;
    localparam logic [3:0] OP_READ  = 4'd1;
    localparam logic [3:0] OP_WRITE = 4'd2;

    typedef struct packed {
        logic [1:0]          spare;
        logic [3:0]          op;
        logic [9:0]          idx;
        logic [SHADOW_W-1:0] data;
    } cmd_word_t;

    typedef enum logic [2:0] {
        SEL_CFG,
        SEL_STS,
        SEL_MASK,
        SEL_MSTAT,
        SEL_CMD,
        SEL_POP,
        SEL_MCTL,
        SEL_NONE
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [31:0] a);
        reg_sel_t s;
        if (a[1:0] != 2'b00) begin
            s = SEL_NONE;
        end else begin
            case (a[31:2])
                30'd0:   s = SEL_CFG;
                30'd1:   s = SEL_STS;
                30'd2:   s = SEL_MASK;
                30'd3:   s = SEL_MSTAT;
                30'd4:   s = SEL_CMD;
                30'd5:   s = SEL_POP;
                30'd6:   s = SEL_MCTL;
                default: s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/adc_data_fifo.sv
module adc_data_fifo #(
    parameter int DEPTH = 15,
    parameter int WIDTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_next,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = empty ? '0 : mem[rd_ptr];

    always_comb begin
        count_next = count;
        if (push_ok && !pop_ok) count_next = count + 1'b1;
        if (pop_ok && !push_ok) count_next = count - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            count <= count_next;
        end
    end

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    assert_full_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)));
    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (count == '0));

endmodule

// File: rtl/adc_cmd_engine.sv
module adc_cmd_engine
    import adc_regif_pkg::*;
#(
    parameter int NUM_REGS = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_strobe,
    input  cmd_word_t           cmd,
    input  logic                hold,
    output logic                push,
    output logic [SHADOW_W-1:0] push_data
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [SHADOW_W-1:0] shadow [NUM_REGS];
    logic [SHADOW_W-1:0] latch_q;
    logic                idx_ok, is_rw, accept;
    logic [IDX_W-1:0]    idx_lo;
    logic                spare_unused;

    assign spare_unused = ^cmd.spare;
    assign idx_ok    = (32'(cmd.idx) < NUM_REGS);
    assign idx_lo    = cmd.idx[IDX_W-1:0];
    assign is_rw     = (cmd.op == OP_READ) || (cmd.op == OP_WRITE);
    assign accept    = cmd_strobe && !hold && ((cmd.op == OP_NOP) || (is_rw && idx_ok));
    assign push      = accept;
    assign push_data = latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else if (accept) begin
            latch_q <= (cmd.op == OP_READ) ? shadow[idx_lo] : '0;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow[g] <= '0;
            end else if (accept && cmd.op == OP_WRITE && idx_lo == IDX_W'(g)) begin
                shadow[g] <= cmd.data;
            end
        end
    end

    assert_hold_latch_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_strobe && hold) |=> $stable(latch_q));
    assert_nonread_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (push && cmd.op != OP_READ) |=> (latch_q == '0));
    assert_bad_index_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_strobe && is_rw && !idx_ok) |=> $stable(latch_q));

endmodule

// File: rtl/adc_irq_unit.sv
module adc_irq_unit
    import adc_regif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             sts_wr,
    input  logic             mask_wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic             data_over,
    output logic [BUS_W-1:0] sts,
    output logic [BUS_W-1:0] mask,
    output logic             irq
);
    logic [BUS_W-1:0] clr_bits, set_bits;

    always_comb begin
        clr_bits = sts_wr ? wdata : '0;
        set_bits = '0;
        set_bits[STS_CMD_LOW] = 1'b1;
        set_bits[STS_DATA_HIGH] = data_over;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts  <= STS_RESET_VAL;
            mask <= MASK_RESET_VAL;
        end else begin
            if (mask_wr) mask <= wdata & MASK_KEEP;
            if (strobe)  sts  <= (sts & ~clr_bits) | set_bits;
        end
    end

    assign irq = |(sts & ~mask);

    assert_cmd_low_R8: assert property (@(posedge clk) disable iff (rst)
        strobe |=> sts[STS_CMD_LOW]);
    assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && wdata[STS_DATA_HIGH] && !data_over) |=> !sts[STS_DATA_HIGH]);
    assert_over_R9: assert property (@(posedge clk) disable iff (rst)
        (strobe && data_over) |=> sts[STS_DATA_HIGH]);
    assert_mask_trim_R10: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> (mask[BUS_W-1:10] == '0));

endmodule

// File: rtl/adc_cmd_regif.sv
module adc_cmd_regif
    import adc_regif_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 15,
    parameter int NUM_REGS   = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    reg_sel_t            sel;
    logic [BUS_W-1:0]    cfg_q, mctl_q, sts, mask, mstat;
    logic                cmd_strobe, pop, strobe, push, data_over;
    logic [SHADOW_W-1:0] push_data, head;
    logic [CNT_W-1:0]    count, count_next;
    logic                empty, full;
    logic [LEVEL_W-1:0]  level;

    assign sel        = decode_addr(32'(bus_addr));
    assign cmd_strobe = bus_wr && (sel == SEL_CMD);
    assign pop        = bus_rd && (sel == SEL_POP);
    assign strobe     = bus_wr || bus_rd;
    assign data_over  = 32'(count_next) > 32'(cfg_q[THR_LSB +: 4]);
    assign level      = LEVEL_W'(count);

    always_comb begin
        mstat = '0;
        mstat[10] = 1'b1;
        mstat[15:12] = level;
        mstat[8] = empty;
        mstat[9] = full;
    end

    adc_cmd_engine #(.NUM_REGS(NUM_REGS)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .cmd_strobe (cmd_strobe),
        .cmd        (cmd_word_t'(bus_wdata)),
        .hold       (mctl_q[MCTL_HOLD]),
        .push       (push),
        .push_data  (push_data)
    );

    adc_data_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(SHADOW_W)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .pop        (pop),
        .din        (push_data),
        .dout       (head),
        .count      (count),
        .count_next (count_next),
        .empty      (empty),
        .full       (full)
    );

    adc_irq_unit u_irq (
        .clk       (clk),
        .rst       (rst),
        .strobe    (strobe),
        .sts_wr    (bus_wr && sel == SEL_STS),
        .mask_wr   (bus_wr && sel == SEL_MASK),
        .wdata     (bus_wdata),
        .data_over (data_over),
        .sts       (sts),
        .mask      (mask),
        .irq       (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET_VAL;
            mctl_q <= MCTL_RESET_VAL;
        end else if (bus_wr) begin
            if (sel == SEL_CFG)  cfg_q  <= bus_wdata;
            if (sel == SEL_MCTL) mctl_q <= bus_wdata & MCTL_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (sel)
                SEL_CFG:   bus_rdata <= cfg_q;
                SEL_STS:   bus_rdata <= sts;
                SEL_MASK:  bus_rdata <= mask;
                SEL_MSTAT: bus_rdata <= mstat;
                SEL_POP:   bus_rdata <= BUS_W'(head);
                SEL_MCTL:  bus_rdata <= mctl_q;
                default:   bus_rdata <= '0;
            endcase
        end
    end

    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (sel == SEL_NONE || sel == SEL_CMD)) |=> (bus_rdata == '0));
    assert_mctl_trim_R12: assert property (@(posedge clk) disable iff (rst)
        (mctl_q & ~MCTL_KEEP) == '0);
    assert_hold_fifo_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_strobe && mctl_q[MCTL_HOLD] && !bus_rd) |=> $stable(count));
    assert_mstat_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_MSTAT) |=> (bus_rdata[10] && (bus_rdata[8] != bus_rdata[15:12]))
            || (bus_rdata[10] && bus_rdata[15:12] == 4'd0 && bus_rdata[8]));

endmodule

// File: tb/adc_cmd_regif_test.sv
module adc_cmd_regif_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #4 clk = ~clk;

    adc_cmd_regif uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R13 read result with no expectation actual=%h expected=none", bus_rdata);
            end else begin
                check32(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        check32({31'd0, irq}, {31'd0, exp}, tag);
    endtask

    function automatic logic [31:0] mk(input logic [3:0] op, input logic [9:0] idx, input logic [15:0] d);
        return {2'b00, op, idx, d};
    endfunction

    localparam logic [7:0] A_CFG = 8'h00, A_STS = 8'h04, A_MASK = 8'h08, A_MST = 8'h0C,
                           A_CMD = 8'h10, A_POP = 8'h14, A_MCTL = 8'h18;

    initial begin
        #(8 * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog expired, all requirements unfinished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values, R11 empty status
        rd(A_CFG,  32'h0000_1814, "R1 cfg reset");
        rd(A_STS,  32'h0000_0200, "R1 status reset");
        rd(A_MASK, 32'hFFFF_FFFF, "R1 mask reset");
        rd(A_MCTL, 32'h0000_0010, "R1 mctl reset");
        rd(A_MST,  32'h0000_0500, "R11 empty mstat");
        chk_irq(1'b0, "R1 irq low after reset");

        // R6 commands dropped while held
        wr(A_CMD, mk(4'd2, 10'd6, 16'h6666));
        wr(A_CMD, mk(4'd0, 10'd0, 16'h0));
        rd(A_MST, 32'h0000_0500, "R6 held command no push");

        // R12 mctl and cfg storage
        wr(A_MCTL, 32'hFFFF_FFFF);
        rd(A_MCTL, 32'h00FF_FEFF, "R12 mctl and-mask");
        wr(A_MCTL, 32'h0);
        rd(A_MCTL, 32'h0, "R12 mctl release");
        wr(A_CFG, 32'hDEAD_BEEF);
        rd(A_CFG, 32'hDEAD_BEEF, "R12 cfg full width");
        wr(A_CFG, 32'h0002_0000);

        // R3 one-command latency, R9 threshold, R10 mask
        wr(A_CMD, mk(4'd2, 10'd5, 16'hABCD));
        wr(A_CMD, mk(4'd1, 10'd5, 16'h0));
        wr(A_CMD, mk(4'd0, 10'd0, 16'h0));
        rd(A_MST, 32'h0000_3400, "R11 level three");
        rd(A_STS, 32'h0000_0300, "R9 level above threshold");
        chk_irq(1'b0, "R10 all masked");
        wr(A_MASK, 32'hFFFF_FEFF);
        rd(A_MASK, 32'h0000_02FF, "R10 mask trim");
        chk_irq(1'b1, "R10 unmasked bit8");
        rd(A_POP, 32'h0, "R3 first push is prior latch");
        rd(A_POP, 32'h0, "R3 write latches zero");
        rd(A_POP, 32'h0000_ABCD, "R3 read value after next cmd");
        rd(A_POP, 32'h0, "R5 pop empty zero");
        rd(A_MST, 32'h0000_0500, "R5 level stays zero");

        // R8 write-one-clear
        wr(A_STS, 32'h0000_0100);
        rd(A_STS, 32'h0000_0200, "R8 w1c with bit9 reset");
        chk_irq(1'b0, "R10 bit9 masked");
        wr(A_MASK, 32'h0);
        chk_irq(1'b1, "R10 bit9 unmasked");
        wr(A_MASK, 32'h3FF);
        chk_irq(1'b0, "R10 remasked");

        // R7 ignored commands
        wr(A_CMD, mk(4'd1, 10'd200, 16'h0));
        wr(A_CMD, mk(4'd1, 10'd128, 16'h0));
        wr(A_CMD, mk(4'd3, 10'd1, 16'h0));
        rd(A_MST, 32'h0000_0500, "R7 bad index or opcode ignored");
        wr(A_CMD, mk(4'd0, 10'd500, 16'h0));
        wr(A_CMD, mk(4'd2, 10'd127, 16'h1234));
        wr(A_CMD, mk(4'd1, 10'd127, 16'h0));
        wr(A_CMD, mk(4'd1, 10'd6, 16'h0));
        wr(A_CMD, mk(4'd0, 10'd0, 16'h0));
        rd(A_MST, 32'h0000_5400, "R7 nop any index accepted");
        rd(A_POP, 32'h0, "R7 pop 1");
        rd(A_POP, 32'h0, "R7 pop 2");
        rd(A_POP, 32'h0, "R7 pop 3");
        rd(A_POP, 32'h0000_1234, "R7 top index readback");
        rd(A_POP, 32'h0, "R6 held write left reg zero");

        // R4 full FIFO
        wr(A_CMD, mk(4'd2, 10'd9, 16'h0777));
        for (int i = 0; i < 14; i++) wr(A_CMD, mk(4'd0, 10'd0, 16'h0));
        wr(A_CMD, mk(4'd1, 10'd9, 16'h0));
        rd(A_MST, 32'h0000_F600, "R4 full status");
        rd(A_POP, 32'h0, "R4 pop while full");
        wr(A_CMD, mk(4'd0, 10'd0, 16'h0));
        rd(A_MST, 32'h0000_F600, "R4 refilled");
        for (int i = 0; i < 14; i++) rd(A_POP, 32'h0, "R4 drain zero");
        rd(A_POP, 32'h0000_0777, "R4 latch updated on dropped push");
        rd(A_MST, 32'h0000_0500, "R11 empty after drain");

        // R2 map and direction
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, 32'h0, "R2 unmapped read zero");
        rd(A_CMD, 32'h0, "R2 write-only reads zero");
        rd(8'h02, 32'h0, "R2 misaligned read zero");
        wr(A_MST, 32'hFFFF_FFFF);
        rd(A_MST, 32'h0000_0500, "R2 read-only mstat");
        wr(A_POP, 32'hFFFF_FFFF);
        rd(A_MST, 32'h0000_0500, "R2 write to pop ignored");
        rd(A_CFG, 32'h0002_0000, "R2 cfg untouched by stray writes");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule